// File: doc/BRIEF.md
# Byte Serial Port with Selectable Bit Clocks

This block moves bytes in and out over a single-wire serial line. Software writes a byte to the data register, and the transmitter sends it as a frame: a low start bit, the eight data bits with the least significant bit first, and a high stop bit. The receiver assembles incoming frames into the same data address, where reads return them. Each direction advances on single-cycle bit-clock pulses. A 3-bit mode field selects where those pulses come from: an external clock pin, audio divider channel 2 or audio divider channel 4. Some modes make the receiver asynchronous. In those modes it oversamples the line, finds the start edge itself and samples each bit near its middle.

Status is read from one byte. It holds three sticky error flags (frame error, receive overrun and keyboard overrun), the live level of the input pin, and an active-low "received byte not ready" bit. The error flags stay set until software writes to a separate clear address. Three interrupt requests each have their own enable bit: received byte ready, transmit byte needed and transmit output finished. A break control holds the output line low.

Register map (4-bit address): 0xD writes the transmit byte and reads the received byte. 0x1 writes the control byte and reads status. A write of any value to 0x2 clears the error flags. 0x3 writes the interrupt enables and reads the pending interrupts.

Top module: `sio_top`

## Requirements
- R1: After reset, the serial output is 1 and no interrupt is requested. A status read then returns 0x1F when the input pin is 1, and 0x0F when the pin is 0.
- R2: A byte written to 0xD goes out as ten bits, one per transmit tick: 0, then data bits 0 to 7, then 1. Each bit appears after the tick that starts it. The line stays at 1 while nothing is queued.
- R3: Control bits 6..4 select the bit clocks. 000 uses the external clock for both directions. 001 transmits on the external clock and receives asynchronously on channel 4. 010 uses channel 4 for both directions. 100 transmits on channel 4 and receives on the external clock. 110 transmits on channel 2 and receives on channel 4. 111 is 110 with asynchronous receive. Ticks from sources that are not selected have no effect.
- R4: While control bit 7 is 1, the serial output is 0, whatever the transmitter is doing.
- R5: In a synchronous receive mode, each receive tick samples one bit. A frame starts at the first tick that samples 0. After the stop-bit tick, 0xD reads the assembled byte and status bit 1 reads 0. Reading 0xD sets status bit 1 back to 1.
- R6: In an asynchronous receive mode, one bit lasts OVS receive ticks. The first tick that sees 0 starts a frame. The start bit is confirmed OVS/2 ticks later, and every later bit is sampled OVS ticks after the previous one. If the line is 1 when the start bit should be confirmed, the frame is dropped.
- R7: A stop bit sampled as 0 sets status bit 7 (frame error).
- R8: A byte that completes while the previous byte is still unread sets status bit 6 (overrun), and the new byte replaces the old one.
- R9: A pulse on kbOverrunEvt sets status bit 5. Status bits 7..5 are cleared only by a write to 0x2.
- R10: Status bit 4 follows the serial input pin. Status bits 3, 2 and 0 always read 1.
- R11: Interrupt enables are written to bits 5 (received byte ready), 4 (transmit byte needed) and 3 (output finished) of 0x3. "Byte needed" fires when the transmit byte moves into the shifter. "Output finished" fires when a stop bit ends with nothing queued. An enabled event sets its pending bit, which reads at the same position of 0x3 and drives irqReq[2], [1] and [0] respectively. Clearing an enable clears its pending bit.
- R12: Mode codes 011 and 101 select no clock, so neither direction shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (read side effects) |
| busAddr | input | 4 | Register address |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, combinational from busAddr |
| extClkTick | input | 1 | External bit clock pulse |
| ch2Tick | input | 1 | Divider channel 2 output pulse |
| ch4Tick | input | 1 | Divider channel 4 output pulse |
| serIn | input | 1 | Serial input line |
| kbOverrunEvt | input | 1 | Keyboard overrun event pulse |
| serOut | output | 1 | Serial output line |
| irqReq | output | 3 | Pending requests: [2] ready, [1] needed, [0] finished |

## Verification
On every cycle, the assertions check these invariants: the three error flags stay set until the clear strobe, a read of the data register drops the ready flag, no interrupt stays pending without its enable, the transmit shifter is all ones whenever it is idle, and the bit and oversample counters stay in range. Only the bench scenarios can show the rest: the exact bit order on the line, the mode table's routing of each tick source, break, mid-bit sampling and the false-start drop in asynchronous receive, and the moments at which each interrupt event fires.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int DATA_W    = 8;
  localparam int FRAME_LEN = DATA_W + 2;
  localparam logic [3:0] A_DATA   = 4'hD;
  localparam logic [3:0] A_CTRL   = 4'h1;
  localparam logic [3:0] A_ERRCLR = 4'h2;
  localparam logic [3:0] A_IRQ    = 4'h3;

  typedef enum logic [1:0] {SRC_NONE, SRC_EXT, SRC_CH2, SRC_CH4} clkSrc_e;

  typedef struct packed {
    logic txTick;
    logic rxTick;
    logic rxAsync;
    logic loadHold;
    logic brk;
  } dpStrobe_t;

  typedef struct packed {
    logic need;
    logic done;
    logic rxDone;
    logic stopBad;
  } dpEvent_t;
endpackage

// File: rtl/sio_datapath.sv
module sio_datapath
  import sio_pkg::*;
#(
  parameter int OVS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         st,
  input  logic [DATA_W-1:0] wrData,
  input  logic              serIn,
  output dpEvent_t          ev,
  output logic [DATA_W-1:0] rxByte,
  output logic              serOut
);
  localparam int REM_W = $clog2(FRAME_LEN + 1);
  localparam int IDX_W = $clog2(FRAME_LEN);
  localparam int CW    = (OVS > 2) ? $clog2(OVS) : 1;
  localparam int HALF  = OVS / 2;

  logic [DATA_W-1:0]    txHold;
  logic                 txFull;
  logic [FRAME_LEN-1:0] txShreg;
  logic [REM_W-1:0]     txRem;
  logic                 txEnding;

  logic                 rxActive;
  logic [IDX_W-1:0]     rxIdx;
  logic [CW-1:0]        rxCnt;
  logic [DATA_W-1:0]    rxShift;
  logic                 rxSample;

  assign txEnding  = (txRem <= REM_W'(1));
  assign ev.need   = st.txTick && txEnding && txFull;
  assign ev.done   = st.txTick && (txRem == REM_W'(1)) && !txFull;
  assign serOut    = st.brk ? 1'b0 : txShreg[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txHold  <= '0;
      txFull  <= 1'b0;
      txShreg <= '1;
      txRem   <= '0;
    end else begin
      if (st.txTick) begin
        if (txEnding) begin
          if (txFull) begin
            txShreg <= {1'b1, txHold, 1'b0};
            txRem   <= REM_W'(FRAME_LEN);
            txFull  <= 1'b0;
          end else begin
            txShreg <= '1;
            txRem   <= '0;
          end
        end else begin
          txShreg <= {1'b1, txShreg[FRAME_LEN-1:1]};
          txRem   <= txRem - REM_W'(1);
        end
      end
      if (st.loadHold) begin
        txHold <= wrData;
        txFull <= 1'b1;
      end
    end
  end

  assign rxSample   = st.rxTick && rxActive && (!st.rxAsync || rxCnt == '0);
  assign ev.rxDone  = rxSample && (rxIdx == IDX_W'(FRAME_LEN - 1));
  assign ev.stopBad = ev.rxDone && !serIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxActive <= 1'b0;
      rxIdx    <= '0;
      rxCnt    <= '0;
      rxShift  <= '0;
      rxByte   <= '0;
    end else if (st.rxTick) begin
      if (!rxActive) begin
        if (!serIn) begin
          rxActive <= 1'b1;
          rxIdx    <= st.rxAsync ? '0 : IDX_W'(1);
          rxCnt    <= CW'(HALF - 1);
        end
      end else if (rxSample) begin
        rxCnt <= CW'(OVS - 1);
        if (rxIdx == '0) begin
          if (serIn) rxActive <= 1'b0;
          else       rxIdx    <= IDX_W'(1);
        end else if (rxIdx == IDX_W'(FRAME_LEN - 1)) begin
          rxByte   <= rxShift;
          rxActive <= 1'b0;
        end else begin
          rxShift <= {serIn, rxShift[DATA_W-1:1]};
          rxIdx   <= rxIdx + IDX_W'(1);
        end
      end else begin
        rxCnt <= rxCnt - CW'(1);
      end
    end
  end

  // R2: an idle transmitter leaves the line high
  a_r2_idle_ones: assert property (@(posedge clk) disable iff (!rstN)
    (txRem == '0) |-> (txShreg == '1));
  a_r2_rem_range: assert property (@(posedge clk) disable iff (!rstN)
    txRem <= REM_W'(FRAME_LEN));
  a_r6_cnt_range: assert property (@(posedge clk) disable iff (!rstN)
    32'(rxCnt) < OVS);
  a_r5_idx_range: assert property (@(posedge clk) disable iff (!rstN)
    rxIdx <= IDX_W'(FRAME_LEN - 1));
endmodule

// File: rtl/sio_ctrl.sv
module sio_ctrl
  import sio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [3:0]        busAddr,
  input  logic [7:3]        cfgBits,
  input  logic              extClkTick,
  input  logic              ch2Tick,
  input  logic              ch4Tick,
  input  logic              serIn,
  input  logic              kbOverrunEvt,
  input  dpEvent_t          ev,
  input  logic [DATA_W-1:0] rxByte,
  output dpStrobe_t         st,
  output logic [7:0]        busRdData,
  output logic [2:0]        irqReq
);
  logic [2:0] mode;
  logic       brk;
  logic [2:0] irqEn, irqEnNext, irqPend, irqEvt;
  logic       frameErr, rxOverrun, kbOverrun, rxValid;
  logic       readRx, clrErr;
  clkSrc_e    txSrc, rxSrc;
  logic       rxAsync;

  always_comb begin
    txSrc = SRC_NONE; rxSrc = SRC_NONE; rxAsync = 1'b0;
    case (mode)
      3'b000: begin txSrc = SRC_EXT; rxSrc = SRC_EXT; end
      3'b001: begin txSrc = SRC_EXT; rxSrc = SRC_CH4; rxAsync = 1'b1; end
      3'b010: begin txSrc = SRC_CH4; rxSrc = SRC_CH4; end
      3'b100: begin txSrc = SRC_CH4; rxSrc = SRC_EXT; end
      3'b110: begin txSrc = SRC_CH2; rxSrc = SRC_CH4; end
      3'b111: begin txSrc = SRC_CH2; rxSrc = SRC_CH4; rxAsync = 1'b1; end
      default: ;
    endcase
  end

  function automatic logic pickTick(clkSrc_e s, logic e, logic c2, logic c4);
    case (s)
      SRC_EXT: return e;
      SRC_CH2: return c2;
      SRC_CH4: return c4;
      default: return 1'b0;
    endcase
  endfunction

  assign readRx      = busRd && busAddr == A_DATA;
  assign clrErr      = busWr && busAddr == A_ERRCLR;
  assign st.txTick   = pickTick(txSrc, extClkTick, ch2Tick, ch4Tick);
  assign st.rxTick   = pickTick(rxSrc, extClkTick, ch2Tick, ch4Tick);
  assign st.rxAsync  = rxAsync;
  assign st.loadHold = busWr && busAddr == A_DATA;
  assign st.brk      = brk;

  assign irqEnNext = (busWr && busAddr == A_IRQ) ? cfgBits[5:3] : irqEn;
  assign irqEvt    = {ev.rxDone, ev.need, ev.done};
  assign irqReq    = irqPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode <= '0; brk <= 1'b0; irqEn <= '0;
      frameErr <= 1'b0; rxOverrun <= 1'b0; kbOverrun <= 1'b0; rxValid <= 1'b0;
    end else begin
      irqEn <= irqEnNext;
      if (busWr && busAddr == A_CTRL) begin
        brk  <= cfgBits[7];
        mode <= cfgBits[6:4];
      end
      if (ev.rxDone)   rxValid <= 1'b1;
      else if (readRx) rxValid <= 1'b0;
      if (clrErr) begin
        frameErr <= 1'b0; rxOverrun <= 1'b0; kbOverrun <= 1'b0;
      end else begin
        if (ev.stopBad)                       frameErr  <= 1'b1;
        if (ev.rxDone && rxValid && !readRx)  rxOverrun <= 1'b1;
        if (kbOverrunEvt)                     kbOverrun <= 1'b1;
      end
    end
  end

  for (genvar i = 0; i < 3; i++) begin : g_irq
    always_ff @(posedge clk) begin
      if (!rstN) irqPend[i] <= 1'b0;
      else       irqPend[i] <= irqEnNext[i] && (irqPend[i] || irqEvt[i]);
    end
  end

  always_comb begin
    case (busAddr)
      A_DATA:  busRdData = rxByte;
      A_CTRL:  busRdData = {frameErr, rxOverrun, kbOverrun, serIn,
                            1'b1, 1'b1, ~rxValid, 1'b1};
      A_IRQ:   busRdData = {2'b00, irqPend, 3'b000};
      default: busRdData = 8'h00;
    endcase
  end

  a_r7_frame_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (frameErr && !clrErr) |=> frameErr);
  a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (rxOverrun && !clrErr) |=> rxOverrun);
  a_r9_kb_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (kbOverrun && !clrErr) |=> kbOverrun);
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (readRx && !ev.rxDone) |=> !rxValid);
  a_r11_gated: assert property (@(posedge clk) disable iff (!rstN)
    (irqPend & ~irqEn) == 3'b000);
endmodule

// File: rtl/sio_top.sv
module sio_top
  import sio_pkg::*;
#(
  parameter int OVS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWr,
  input  logic       busRd,
  input  logic [3:0] busAddr,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData,
  input  logic       extClkTick,
  input  logic       ch2Tick,
  input  logic       ch4Tick,
  input  logic       serIn,
  input  logic       kbOverrunEvt,
  output logic       serOut,
  output logic [2:0] irqReq
);
  dpStrobe_t         st;
  dpEvent_t          ev;
  logic [DATA_W-1:0] rxByte;

  sio_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .cfgBits(busWrData[7:3]), .extClkTick(extClkTick), .ch2Tick(ch2Tick),
    .ch4Tick(ch4Tick), .serIn(serIn), .kbOverrunEvt(kbOverrunEvt),
    .ev(ev), .rxByte(rxByte), .st(st), .busRdData(busRdData), .irqReq(irqReq)
  );

  sio_datapath #(.OVS(OVS)) i_dp (
    .clk(clk), .rstN(rstN), .st(st), .wrData(busWrData), .serIn(serIn),
    .ev(ev), .rxByte(rxByte), .serOut(serOut)
  );
endmodule

// File: tb/test_sio_top.sv
module test_sio_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWr = 1'b0, busRd = 1'b0;
  logic [3:0] busAddr = 4'h0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic       extClkTick = 1'b0, ch2Tick = 1'b0, ch4Tick = 1'b0;
  logic       serIn = 1'b1, kbOverrunEvt = 1'b0;
  logic       serOut;
  logic [2:0] irqReq;
  int         errors = 0, checks = 0;
  bit         finished = 1'b0;

  localparam logic [3:0] DATA = 4'hD, CTRL = 4'h1, ERRCLR = 4'h2, IRQ = 4'h3;
  localparam int OVS = 4;

  always #4 clk = ~clk;

  sio_top #(.OVS(OVS)) i_sio_top (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    busWr = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    busRd = 1'b1; busAddr = a;
    #1 d = busRdData;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic peek(logic [3:0] a, output logic [7:0] d);
    busAddr = a;
    #1 d = busRdData;
  endtask

  // src: 0 ext, 2 ch2, 4 ch4
  task automatic tick(int src);
    if (src == 0) extClkTick = 1'b1;
    if (src == 2) ch2Tick = 1'b1;
    if (src == 4) ch4Tick = 1'b1;
    @(negedge clk);
    extClkTick = 1'b0; ch2Tick = 1'b0; ch4Tick = 1'b0;
  endtask

  task automatic txFrame(string req, int src, logic [7:0] b);
    logic [9:0] f;
    f = {1'b1, b, 1'b0};
    wr(DATA, b);
    for (int k = 0; k < 10; k++) begin
      tick(src);
      chk(req, 8'(serOut), 8'(f[k]));
    end
    tick(src);
    chk(req, 8'(serOut), 8'h01);
  endtask

  task automatic rxSync(int src, logic [7:0] b, logic stopBit);
    logic [9:0] f;
    f = {stopBit, b, 1'b0};
    for (int k = 0; k < 10; k++) begin
      serIn = f[k];
      tick(src);
    end
    serIn = 1'b1;
  endtask

  task automatic rxAsync(logic [7:0] b);
    logic [9:0] f;
    f = {1'b1, b, 1'b0};
    for (int k = 0; k < 10; k++) begin
      serIn = f[k];
      repeat (OVS) tick(4);
    end
    serIn = 1'b1;
  endtask

  task automatic testReset();
    logic [7:0] d;
    chk("R1 serOut", 8'(serOut), 8'h01);
    chk("R1 irq", 8'(irqReq), 8'h00);
    peek(CTRL, d); chk("R1 status", d, 8'h1F);
    serIn = 1'b0;
    peek(CTRL, d); chk("R10 live pin low", d, 8'h0F);
    serIn = 1'b1;
  endtask

  task automatic testTx();
    wr(CTRL, 8'h20);
    txFrame("R2 frame A5", 4, 8'hA5);
    txFrame("R2 frame 3C", 4, 8'h3C);
  endtask

  task automatic testModes();
    wr(CTRL, 8'h00);
    wr(DATA, 8'h81);
    tick(4); tick(2);
    chk("R3 mode000 ch ignored", 8'(serOut), 8'h01);
    tick(0); chk("R3 mode000 ext start", 8'(serOut), 8'h00);
    repeat (10) tick(0);
    chk("R3 mode000 end", 8'(serOut), 8'h01);
    wr(CTRL, 8'h40);
    txFrame("R3 mode100 ch4", 4, 8'h5A);
    wr(CTRL, 8'h60);
    wr(DATA, 8'h0F);
    tick(4); tick(0);
    chk("R3 mode110 others ignored", 8'(serOut), 8'h01);
    tick(2); chk("R3 mode110 ch2 start", 8'(serOut), 8'h00);
    repeat (10) tick(2);
  endtask

  task automatic testBreak();
    wr(CTRL, 8'hA0);
    chk("R4 break idle", 8'(serOut), 8'h00);
    wr(DATA, 8'hFF);
    tick(4); tick(4);
    chk("R4 break during data", 8'(serOut), 8'h00);
    wr(CTRL, 8'h20);
    chk("R4 released", 8'(serOut), 8'h01);
    repeat (9) tick(4);
  endtask

  task automatic testRxSync();
    logic [7:0] d;
    wr(CTRL, 8'h00);
    rxSync(0, 8'hC3, 1'b1);
    peek(CTRL, d); chk("R5 ready bit low", d, 8'h1D);
    rd(DATA, d); chk("R5 data", d, 8'hC3);
    peek(CTRL, d); chk("R5 read clears ready", d, 8'h1F);
    wr(CTRL, 8'h40);
    rxSync(0, 8'h96, 1'b1);
    rd(DATA, d); chk("R3 mode100 rx ext", d, 8'h96);
  endtask

  task automatic testRxAsync();
    logic [7:0] d;
    wr(CTRL, 8'h10);
    serIn = 1'b0; tick(4);
    serIn = 1'b1; repeat (12) tick(4);
    peek(CTRL, d); chk("R6 false start dropped", d, 8'h1F);
    rxAsync(8'h6B);
    peek(CTRL, d); chk("R6 async ready", d, 8'h1D);
    rd(DATA, d); chk("R6 async data", d, 8'h6B);
    wr(CTRL, 8'h70);
    rxAsync(8'h2D);
    rd(DATA, d); chk("R3 mode111 async data", d, 8'h2D);
  endtask

  task automatic testErrors();
    logic [7:0] d;
    wr(CTRL, 8'h00);
    rxSync(0, 8'h11, 1'b0);
    peek(CTRL, d); chk("R7 frame error", d, 8'h9D);
    rd(DATA, d);
    rxSync(0, 8'h22, 1'b1);
    rxSync(0, 8'h33, 1'b1);
    peek(CTRL, d); chk("R8 overrun", d, 8'hDD);
    rd(DATA, d); chk("R8 newest byte kept", d, 8'h33);
    kbOverrunEvt = 1'b1; @(negedge clk); kbOverrunEvt = 1'b0;
    repeat (3) @(negedge clk);
    peek(CTRL, d); chk("R9 kb overrun sticky", d, 8'hFF);
    wr(ERRCLR, 8'h00);
    peek(CTRL, d); chk("R9 clear strobe", d, 8'h1F);
  endtask

  task automatic testIrq();
    logic [7:0] d;
    wr(CTRL, 8'h20);
    wr(IRQ, 8'h38);
    wr(DATA, 8'h44);
    chk("R11 none yet", 8'(irqReq), 8'h00);
    tick(4);
    chk("R11 byte needed", 8'(irqReq), 8'h02);
    repeat (10) tick(4);
    chk("R11 output finished", 8'(irqReq), 8'h03);
    rxSync(4, 8'h77, 1'b1);
    chk("R11 byte ready", 8'(irqReq), 8'h07);
    peek(IRQ, d); chk("R11 pending read", d, 8'h38);
    rd(DATA, d);
    wr(IRQ, 8'h08);
    chk("R11 disable clears", 8'(irqReq), 8'h01);
    wr(IRQ, 8'h00);
    chk("R11 all cleared", 8'(irqReq), 8'h00);
  endtask

  task automatic testUndef();
    logic [7:0] d;
    wr(CTRL, 8'h30);
    wr(DATA, 8'h00);
    tick(0); tick(2); tick(4);
    chk("R12 mode011 no tx", 8'(serOut), 8'h01);
    rxSync(0, 8'h00, 1'b0);
    rxSync(4, 8'h00, 1'b0);
    peek(CTRL, d); chk("R12 mode011 no rx", d, 8'h1F);
    wr(CTRL, 8'h50);
    tick(0); tick(2); tick(4);
    chk("R12 mode101 no tx", 8'(serOut), 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTx();
    testModes();
    testBreak();
    testRxSync();
    testRxAsync();
    testErrors();
    testIrq();
    testUndef();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule